// File: doc/BRIEF.md
# Acknowledged Receive FIFO Index Controller

This block runs the index bookkeeping of a receive FIFO whose elements live in a shared message RAM. It holds a put index, a get index and a fill level. From a configured RAM base, a FIFO start offset and the payload size, it produces the word address where the receive path writes the next element. It also produces the word address of the oldest unread element for the host.

The host never pops elements one at a time. It reads as many elements as it likes and then acknowledges them by presenting the index of the last element it consumed. The controller frees every slot up to and including that index in one cycle.

When the FIFO is full, one of two modes applies. In blocking mode the arriving element is refused and a sticky lost flag is raised. In overwrite mode the arriving element takes the slot of the oldest one, and both indices step forward.

Top module: `rxq_index_ctrl`

## Requirements
- R1: After synchronous reset the fill level, get index and put index are 0, and full and lost are low.
- R2: A write request while the FIFO has room asserts wr_ok in the same cycle, with wr_addr equal to ram_base + start + put_idx × element words. After the clock edge put_idx has advanced by one, wrapping to 0 after depth−1, and the level has risen by one.
- R3: The element size in words is 2 header words plus the data words. The data words are 2 for payloads of 0 to 8 bytes and ceil(bytes/4) above that, so 12 bytes gives 5 words and 64 bytes gives 18 words.
- R4: rd_addr always equals ram_base + start + get_idx × element words, in 16-bit word addresses that wrap modulo 2^16.
- R5: In blocking mode (cfg_overwrite = 0), a write to a full FIFO gives wr_ok low and wr_drop high. It leaves the level, put_idx and get_idx unchanged and sets lost.
- R6: In overwrite mode (cfg_overwrite = 1), a write to a full FIFO gives wr_ok high at the address of the current put_idx. Both indices advance by one, the level stays at depth, and lost is not set.
- R7: An accepted acknowledge of index k sets get_idx to (k+1) mod depth. It lowers the level by the number of slots freed, which is ((k − get_idx) mod depth) + 1.
- R8: An acknowledge is ignored, and get_idx and the level are left unchanged, when k ≥ depth or when the number of slots it would free exceeds the level.
- R9: lost stays high until a cycle with lost_clr high and no drop. A drop in the same cycle as lost_clr leaves lost high.
- R10: The depth can be set from 1 to 64. full is high exactly when the level equals the depth, and all indices wrap at the configured depth.
- R11: When an acknowledge and a write arrive in the same cycle, the acknowledge is applied first. The write then sees the room the acknowledge freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_depth | input | 7 | FIFO depth in elements, 1 to 64 |
| cfg_overwrite | input | 1 | 0 = blocking when full, 1 = overwrite oldest |
| cfg_ram_base | input | 16 | Word address of the message RAM base |
| cfg_start | input | 16 | Word offset of the FIFO inside the RAM |
| cfg_payload_bytes | input | 7 | Largest data field stored per element, 0 to 64 bytes |
| wr_req | input | 1 | Receive path offers a new element |
| wr_ok | output | 1 | The element is accepted this cycle; write it at wr_addr |
| wr_drop | output | 1 | The element is refused (blocking mode, full) |
| wr_addr | output | 16 | Word address of the slot at put_idx |
| ack_req | input | 1 | Host acknowledges consumed elements |
| ack_idx | input | 6 | Index of the last element the host read |
| lost_clr | input | 1 | Clears the sticky lost flag |
| rd_addr | output | 16 | Word address of the oldest unread element |
| level | output | 7 | Number of stored elements |
| get_idx | output | 6 | Index of the oldest element |
| put_idx | output | 6 | Index of the next free slot |
| full | output | 1 | Level equals depth |
| lost | output | 1 | Sticky flag for a refused element |

## Verification
The bench targets the cases where index arithmetic most easily slips. An acknowledge whose index lies below the get index must count slots across the wrap; a design that skips the modulo frees a huge or negative count and corrupts the level. A depth of one, where both indices stay at 0, catches a design that wraps at the maximum depth instead of the configured one. An overwrite into a full FIFO must move the get index too, or the host would reread a slot that has just been replaced. An acknowledge in the same cycle as a write to a full FIFO separates ack-first ordering from a design that drops the write; out-of-range and over-level acknowledges must leave the state untouched.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic {
        RXQ_BLOCK     = 1'b0,
        RXQ_OVERWRITE = 1'b1
    } rxq_mode_e;

    typedef struct packed {
        logic ok;
        logic drop;
    } rxq_wr_t;

    localparam int unsigned RXQ_HDR_WORDS = 2;
    localparam int unsigned RXQ_MIN_DATA_WORDS = 2;

    // Words in one stored element: header plus data, data rounded up to whole words.
    function automatic int unsigned elem_words_f(input int unsigned bytes);
        int unsigned data_w;
        data_w = (bytes + 3) / 4;
        if (data_w < RXQ_MIN_DATA_WORDS) data_w = RXQ_MIN_DATA_WORDS;
        return RXQ_HDR_WORDS + data_w;
    endfunction

endpackage

// File: rtl/rxq_addr_gen.sv
module rxq_addr_gen #(
    parameter int ADDR_W  = 16,
    parameter int IDX_W   = 6,
    parameter int WORDS_W = 5
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W-1:0]  start,
    input  logic [IDX_W-1:0]   idx,
    input  logic [WORDS_W-1:0] words,
    output logic [ADDR_W-1:0]  addr
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = ADDR_W'(idx) * ADDR_W'(words);
        addr   = base + start + offset;
    end
endmodule

// File: rtl/rxq_ptr_ctrl.sv
module rxq_ptr_ctrl
    import rxq_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int LVL_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] cfg_depth,
    input  rxq_mode_e        mode,
    input  logic             wr_req,
    input  logic             ack_req,
    input  logic [IDX_W-1:0] ack_idx,
    input  logic             lost_clr,
    output logic [IDX_W-1:0] put_idx,
    output logic [IDX_W-1:0] get_idx,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             lost,
    output rxq_wr_t          wr_res
);
    logic [LVL_W-1:0] put_l, get_l, ack_l, freed, lvl_a, get_a;
    logic [LVL_W-1:0] put_n, get_n, lvl_n;
    logic             ack_ok, room;

    function automatic logic [LVL_W-1:0] wrap_inc(input logic [LVL_W-1:0] i,
                                                  input logic [LVL_W-1:0] d);
        logic [LVL_W-1:0] s;
        s = i + LVL_W'(1);
        return (s >= d) ? '0 : s;
    endfunction

    always_comb begin
        put_l = {1'b0, put_idx};
        get_l = {1'b0, get_idx};
        ack_l = {1'b0, ack_idx};
        // slots from get up to and including the acknowledged one
        if (ack_l >= get_l) freed = ack_l - get_l + LVL_W'(1);
        else                freed = ack_l + cfg_depth - get_l + LVL_W'(1);
        ack_ok = ack_req && (ack_l < cfg_depth) && (freed <= level) && (level != '0);
        lvl_a  = ack_ok ? level - freed : level;
        get_a  = ack_ok ? wrap_inc(ack_l, cfg_depth) : get_l;
        room   = lvl_a < cfg_depth;
        wr_res.ok   = wr_req && (room || mode == RXQ_OVERWRITE);
        wr_res.drop = wr_req && !room && mode == RXQ_BLOCK;
        put_n = wr_res.ok ? wrap_inc(put_l, cfg_depth) : put_l;
        get_n = (wr_res.ok && !room) ? wrap_inc(get_a, cfg_depth) : get_a;
        lvl_n = (wr_res.ok && room) ? lvl_a + LVL_W'(1) : lvl_a;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            put_idx <= '0;
            get_idx <= '0;
            level   <= '0;
            lost    <= 1'b0;
        end else begin
            put_idx <= IDX_W'(put_n);
            get_idx <= IDX_W'(get_n);
            level   <= lvl_n;
            if (wr_res.drop)   lost <= 1'b1;
            else if (lost_clr) lost <= 1'b0;
        end
    end

    assign full = (level == cfg_depth);

    assert_level_bound_R10: assert property (@(posedge clk) disable iff (rst)
        level <= cfg_depth);

    assert_full_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        full |-> (put_idx == get_idx));

    assert_block_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_req && full && !ack_req && mode == RXQ_BLOCK)
        |=> (level == $past(level) && put_idx == $past(put_idx) && lost));

    assert_overwrite_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_req && full && !ack_req && mode == RXQ_OVERWRITE)
        |=> (full && !$rose(lost)));

    assert_lost_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (lost && !lost_clr) |=> lost);

    assert_ack_frees_R7: assert property (@(posedge clk) disable iff (rst)
        (ack_ok && !wr_req) |=> (level < $past(level)));

    assert_ack_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_req && !ack_ok && !wr_req) |=> ($stable(level) && $stable(get_idx)));
endmodule

// File: rtl/rxq_index_ctrl.sv
module rxq_index_ctrl
    import rxq_pkg::*;
#(
    parameter int MAX_DEPTH = 64,
    parameter int ADDR_W    = 16,
    parameter int PAYLOAD_W = 7,
    localparam int IDX_W    = $clog2(MAX_DEPTH),
    localparam int LVL_W    = IDX_W + 1,
    localparam int WORDS_W  = $clog2(elem_words_f(2 ** PAYLOAD_W) + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LVL_W-1:0]     cfg_depth,
    input  logic                 cfg_overwrite,
    input  logic [ADDR_W-1:0]    cfg_ram_base,
    input  logic [ADDR_W-1:0]    cfg_start,
    input  logic [PAYLOAD_W-1:0] cfg_payload_bytes,
    input  logic                 wr_req,
    output logic                 wr_ok,
    output logic                 wr_drop,
    output logic [ADDR_W-1:0]    wr_addr,
    input  logic                 ack_req,
    input  logic [IDX_W-1:0]     ack_idx,
    input  logic                 lost_clr,
    output logic [ADDR_W-1:0]    rd_addr,
    output logic [LVL_W-1:0]     level,
    output logic [IDX_W-1:0]     get_idx,
    output logic [IDX_W-1:0]     put_idx,
    output logic                 full,
    output logic                 lost
);
    rxq_mode_e          mode;
    rxq_wr_t            wr_res;
    logic [WORDS_W-1:0] elem_words;
    logic [IDX_W-1:0]   port_idx  [2];
    logic [ADDR_W-1:0]  port_addr [2];

    assign mode       = cfg_overwrite ? RXQ_OVERWRITE : RXQ_BLOCK;
    assign elem_words = WORDS_W'(elem_words_f(int'(cfg_payload_bytes)));

    rxq_ptr_ctrl #(.IDX_W(IDX_W), .LVL_W(LVL_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .cfg_depth (cfg_depth),
        .mode      (mode),
        .wr_req    (wr_req),
        .ack_req   (ack_req),
        .ack_idx   (ack_idx),
        .lost_clr  (lost_clr),
        .put_idx   (put_idx),
        .get_idx   (get_idx),
        .level     (level),
        .full      (full),
        .lost      (lost),
        .wr_res    (wr_res)
    );

    assign port_idx[0] = put_idx;
    assign port_idx[1] = get_idx;

    for (genvar p = 0; p < 2; p++) begin : g_addr
        rxq_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORDS_W(WORDS_W)) u_addr (
            .base  (cfg_ram_base),
            .start (cfg_start),
            .idx   (port_idx[p]),
            .words (elem_words),
            .addr  (port_addr[p])
        );
    end

    assign wr_ok   = wr_res.ok;
    assign wr_drop = wr_res.drop;
    assign wr_addr = port_addr[0];
    assign rd_addr = port_addr[1];

    assert_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(wr_ok && wr_drop));
endmodule

// File: tb/rxq_index_ctrl_bench.sv
module rxq_index_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  cfg_depth = 7'd4;
    logic        cfg_overwrite = 1'b0;
    logic [15:0] cfg_ram_base = 16'h0000;
    logic [15:0] cfg_start = 16'h0000;
    logic [6:0]  cfg_payload_bytes = 7'd64;
    logic        wr_req = 1'b0, ack_req = 1'b0, lost_clr = 1'b0;
    logic [5:0]  ack_idx = '0;
    logic        wr_ok, wr_drop, full, lost;
    logic [15:0] wr_addr, rd_addr;
    logic [6:0]  level;
    logic [5:0]  get_idx, put_idx;

    int n_checks = 0, n_err = 0;
    int m_put, m_get, m_lvl, m_lost, m_depth, m_ovw, m_base, m_start, m_bytes;

    always #5 clk = ~clk;

    rxq_index_ctrl u_rxq_index_ctrl (
        .clk, .rst, .cfg_depth, .cfg_overwrite, .cfg_ram_base, .cfg_start,
        .cfg_payload_bytes, .wr_req, .wr_ok, .wr_drop, .wr_addr, .ack_req,
        .ack_idx, .lost_clr, .rd_addr, .level, .get_idx, .put_idx, .full, .lost
    );

    function automatic int exp_words(int b);
        int d;
        d = (b <= 8) ? 2 : (b + 3) / 4;
        return 2 + d;
    endfunction

    function automatic int exp_addr(int idx);
        return (m_base + m_start + idx * exp_words(m_bytes)) % 65536;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_state(string req);
        check(req, "level", int'(level), m_lvl);
        check(req, "get_idx", int'(get_idx), m_get);
        check(req, "put_idx", int'(put_idx), m_put);
        check(req, "full", int'(full), int'(m_lvl == m_depth));
        check(req, "lost", int'(lost), m_lost);
        check(req, "rd_addr", int'(rd_addr), exp_addr(m_get));
    endtask

    task automatic configure(int depth, int bytes, int ovw, int base, int start);
        @(negedge clk);
        rst = 1'b1;
        cfg_depth = 7'(depth); cfg_payload_bytes = 7'(bytes);
        cfg_overwrite = ovw[0]; cfg_ram_base = 16'(base); cfg_start = 16'(start);
        m_depth = depth; m_bytes = bytes; m_ovw = ovw; m_base = base; m_start = start;
        m_put = 0; m_get = 0; m_lvl = 0; m_lost = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One cycle: drive at negedge, check combinational outputs, clock, check state.
    task automatic step(int wr, int ack, int k, int clr, string req);
        int freed, lvl_a, get_a, exp_ok, exp_drop, room;
        wr_req = wr[0]; ack_req = ack[0]; ack_idx = 6'(k); lost_clr = clr[0];
        freed = (k >= m_get) ? k - m_get + 1 : k + m_depth - m_get + 1;
        lvl_a = m_lvl; get_a = m_get;
        if (ack != 0 && k < m_depth && freed <= m_lvl && m_lvl != 0) begin
            lvl_a = m_lvl - freed;
            get_a = (k + 1) % m_depth;
        end
        room = int'(lvl_a < m_depth);
        exp_ok = int'(wr != 0 && (room != 0 || m_ovw != 0));
        exp_drop = int'(wr != 0 && room == 0 && m_ovw == 0);
        #1;
        check(req, "wr_ok", int'(wr_ok), exp_ok);
        check(req, "wr_drop", int'(wr_drop), exp_drop);
        if (exp_ok != 0) check(req, "wr_addr", int'(wr_addr), exp_addr(m_put));
        if (exp_ok != 0) begin
            m_put = (m_put + 1) % m_depth;
            if (room != 0) lvl_a++;
            else get_a = (get_a + 1) % m_depth;
        end
        m_lvl = lvl_a; m_get = get_a;
        if (exp_drop != 0) m_lost = 1;
        else if (clr != 0) m_lost = 0;
        @(posedge clk);
        @(negedge clk);
        wr_req = 1'b0; ack_req = 1'b0; lost_clr = 1'b0;
        check_state(req);
    endtask

    task automatic t_reset();
        configure(4, 64, 0, 16'h0100, 16'h0020);
        check_state("R1");
    endtask

    task automatic t_block_fill();
        configure(4, 64, 0, 16'h0100, 16'h0020);
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R5");
        step(1, 0, 0, 0, "R5");
        check("R10", "full after fill", int'(full), 1);
    endtask

    task automatic t_ack();
        configure(4, 64, 0, 16'h0100, 16'h0020);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R2");
        step(0, 1, 1, 0, "R7");
        check("R4", "rd_addr after ack", int'(rd_addr), 16'h0120 + 2 * 18);
        step(0, 1, 5, 0, "R8");
        step(0, 1, 3, 0, "R8");
        step(0, 1, 2, 0, "R7");
        step(0, 1, 2, 0, "R8");
    endtask

    task automatic t_lost_clr();
        configure(2, 8, 0, 0, 16'h0040);
        step(1, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R5");
        step(0, 0, 0, 0, "R9");
        step(1, 0, 0, 1, "R9");
        step(0, 0, 0, 1, "R9");
        check("R9", "lost cleared", int'(lost), 0);
    endtask

    task automatic t_overwrite();
        configure(3, 64, 1, 16'h0200, 0);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R2");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R6");
        check("R6", "get_idx after overwrites", int'(get_idx), 1);
        step(0, 1, 2, 0, "R7");
    endtask

    task automatic t_wrap();
        configure(5, 8, 0, 16'hFFF0, 16'h0008);
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R2");
        step(0, 1, 2, 0, "R7");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R10");
        step(0, 1, 0, 0, "R7");
        step(0, 1, 1, 0, "R7");
        step(0, 1, 1, 0, "R8");
    endtask

    task automatic t_depth_one();
        configure(1, 20, 0, 16'h0010, 16'h0010);
        step(1, 0, 0, 0, "R10");
        step(1, 0, 0, 0, "R5");
        step(0, 1, 0, 0, "R7");
        step(1, 0, 0, 1, "R10");
    endtask

    task automatic t_full_64();
        configure(64, 12, 0, 16'h0400, 16'h0004);
        for (int i = 0; i < 64; i++) step(1, 0, 0, 0, "R10");
        step(1, 0, 0, 0, "R5");
        step(0, 1, 63, 0, "R7");
        step(0, 1, 63, 0, "R8");
    endtask

    task automatic t_same_cycle();
        configure(2, 64, 0, 0, 0);
        step(1, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R2");
        step(1, 1, 0, 0, "R11");
        check("R11", "no lost on ack+write", int'(lost), 0);
        configure(2, 64, 1, 0, 0);
        step(1, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R2");
        step(1, 1, 1, 0, "R11");
    endtask

    task automatic t_elem_size();
        int sizes[6] = '{0, 8, 9, 12, 48, 64};
        foreach (sizes[j]) begin
            configure(4, sizes[j], 0, 0, 16'h0010);
            step(1, 0, 0, 0, "R3");
            step(1, 0, 0, 0, "R3");
            check("R3", "element stride", int'(wr_addr), 16 + 2 * exp_words(sizes[j]));
        end
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_block_fill();
                t_ack();
                t_lost_clr();
                t_overwrite();
                t_wrap();
                t_depth_one();
                t_full_64();
                t_same_cycle();
                t_elem_size();
            end
            begin
                repeat (100000) @(posedge clk);
                n_err++;
                n_checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule